// File: doc/BRIEF.md
# Two-Wire Memory Slave Read Sequencer

This block is the byte-level protocol core of a two-wire serial memory slave holding a 32 KiB array. A framing stage ahead of it has already turned the bus into single-cycle strobes: a received byte, a start condition, a stop condition, and the master's acknowledge bit after each byte the slave sends. The sequencer decides which received bytes the slave acknowledges. It keeps the internal byte address counter and tells the data path when it should drive read data, and from which address.

An address is loaded by a write-mode select followed by two address bytes. A repeated start and a read-mode select then return the byte at that address. A read-mode select alone returns the byte at the current counter. The counter advances after every byte sent. If the master acknowledges, the next byte follows; if it does not, the slave stops sending and goes back to standby. The counter wraps from the top of the array to zero. While an internal write cycle is running, the select byte is not acknowledged. A master can therefore poll until the slave answers.

Top module: `eeprom_rd_seq`

## Requirements
- R1: After reset, ack_o is 0, tx_en is 0 and rd_addr is 0.
- R2: A select byte is {type[7:4]=4'b1010, chip[3:1]=DEV_CHIP, rw[0]}. With rw=0 and no write cycle in progress, it is acknowledged, and so are the next two address bytes. After the second address byte, rd_addr = {first byte bits 6:0, second byte}, and bit 7 of the first byte is ignored.
- R3: While wr_busy is 1, a matching select byte is not acknowledged, and later bytes are not acknowledged until the next start. Once wr_busy is 0, a matching select byte after a start is acknowledged.
- R4: A select byte whose type or chip bits do not match is not acknowledged, and every byte after it is ignored (no ack_o) until the next start.
- R5: A matching select with rw=1 is acknowledged. tx_en then goes to 1, and rd_addr holds the current counter.
- R6: In the master acknowledge slot of a read, an acknowledge (mack=1) increments rd_addr by one and keeps tx_en at 1.
- R7: A not-acknowledge (mack=0) increments rd_addr by one and drops tx_en to 0. Later bytes get no ack_o until a start.
- R8: The counter wraps from 15'h7FFF to 15'h0000 while reading.
- R9: A start strobe wins over a byte or master acknowledge strobe in the same cycle. That byte is not acknowledged, the counter is unchanged, tx_en goes to 0, and the next byte is treated as a select.
- R10: A stop strobe drops tx_en to 0, and bytes after it are not acknowledged until a start.
- R11: Data bytes after the two address bytes of a write-mode select are acknowledged and leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: a byte was received |
| byte_data | input | 8 | Received byte, valid with byte_vld |
| start_evt | input | 1 | One-cycle strobe: start or repeated start |
| stop_evt | input | 1 | One-cycle strobe: stop condition |
| mack_vld | input | 1 | One-cycle strobe: master acknowledge slot after a sent byte |
| mack | input | 1 | 1 = master acknowledged, valid with mack_vld |
| wr_busy | input | 1 | Internal write cycle in progress |
| ack_o | output | 1 | One-cycle pulse the cycle after byte_vld: slave acknowledges that byte |
| tx_en | output | 1 | Slave is sending read data |
| rd_addr | output | 15 | Internal address counter; address of the byte to send |

## Verification
Two functions can fall in the same cycle: a start that aborts the transfer, and a master acknowledge slot that advances the counter. A start and a received byte can also coincide. The bench raises the start strobe together with the master acknowledge strobe in the middle of a sequential read, and together with a select byte while idle. It judges the result by rd_addr staying put, tx_en dropping, no ack_o for the coincident byte, and an acknowledged select on the next byte. Random reads near the top of the array mix counter wrap into sequential reads.

// File: rtl/eers_pkg.sv
package eers_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ADH, ST_ADL, ST_WDAT, ST_RD, ST_IGN
  } seq_st_e;
endpackage

// File: rtl/eers_sel_dec.sv
module eers_sel_dec #(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter logic [2:0] DEV_CHIP = 3'b000
) (
  input  logic [7:0] sel_byte,
  output logic       sel_hit,
  output logic       sel_rw
);
  // layout: type in the high nibble, chip bits below it, direction in bit 0
  assign sel_hit = (sel_byte[7:4] == DEV_TYPE) && (sel_byte[3:1] == DEV_CHIP);
  assign sel_rw  = sel_byte[0];
endmodule

// File: rtl/eers_addr_ctr.sv
module eers_addr_ctr #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld | inc;
    cnt_d  = cnt_q;
    if (ld)       cnt_d = ld_val;
    else if (inc) cnt_d = cnt_q + 1'b1;  // natural wrap at the array end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> (cnt == $past(cnt) + 1'b1));  // R6
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cnt));  // R11
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eers_pkg::*;
#(
  parameter int         AW       = 15,
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter logic [2:0] DEV_CHIP = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          mack_vld,
  input  logic          mack,
  input  logic          wr_busy,
  output logic          ack_o,
  output logic          tx_en,
  output logic [AW-1:0] rd_addr
);
  localparam int HI_W = AW - 8;

  seq_st_e           st_q, st_d;
  logic              ack_q, ack_d;
  logic [HI_W-1:0]   hi_q;
  logic              hi_en, ld, inc;
  logic              sel_hit, sel_rw;

  eers_sel_dec #(.DEV_TYPE(DEV_TYPE), .DEV_CHIP(DEV_CHIP)) u_sel (
    .sel_byte (byte_data),
    .sel_hit  (sel_hit),
    .sel_rw   (sel_rw)
  );

  eers_addr_ctr #(.AW(AW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ld),
    .ld_val ({hi_q, byte_data}),
    .inc    (inc),
    .cnt    (rd_addr)
  );

  always_comb begin
    st_d  = st_q;
    ack_d = 1'b0;
    hi_en = 1'b0;
    ld    = 1'b0;
    inc   = 1'b0;
    if (start_evt) begin
      st_d = ST_SEL;                       // start beats every other strobe
    end else if (stop_evt) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_SEL: if (byte_vld) begin
          if (sel_hit && !wr_busy) begin
            ack_d = 1'b1;
            st_d  = sel_rw ? ST_RD : ST_ADH;
          end else begin
            st_d  = ST_IGN;
          end
        end
        ST_ADH: if (byte_vld) begin
          ack_d = 1'b1;
          hi_en = 1'b1;
          st_d  = ST_ADL;
        end
        ST_ADL: if (byte_vld) begin
          ack_d = 1'b1;
          ld    = 1'b1;
          st_d  = ST_WDAT;
        end
        ST_WDAT: if (byte_vld) ack_d = 1'b1;
        ST_RD: if (mack_vld) begin
          inc = 1'b1;
          if (!mack) st_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= byte_data[HI_W-1:0];
  end

  assign ack_o = ack_q;
  assign tx_en = (st_q == ST_RD);

  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(byte_vld));  // R2
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL && byte_vld && wr_busy && !start_evt) |=> !ack_o);  // R3
  AST_MISMATCH_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGN && !start_evt) |=> !ack_o);  // R4
  AST_NACK_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && mack_vld && !mack && !start_evt) |=> !tx_en);  // R7
  AST_START_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st_q == ST_SEL && !ack_o && !tx_en));  // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (!tx_en && !ack_o));  // R10
endmodule

// File: tb/sim_eeprom_rd_seq.sv
`timescale 1ns/1ps
module sim_eeprom_rd_seq;
  logic        clk, rst_n;
  logic        byte_vld, start_evt, stop_evt, mack_vld, mack, wr_busy;
  logic [7:0]  byte_data;
  logic        ack_o, tx_en;
  logic [14:0] rd_addr;

  int checks = 0;
  int errors = 0;
  logic [14:0] exp_ctr;
  int unsigned seed_dummy;

  eeprom_rd_seq u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .start_evt(start_evt), .stop_evt(stop_evt), .mack_vld(mack_vld),
    .mack(mack), .wr_busy(wr_busy), .ack_o(ack_o), .tx_en(tx_en),
    .rd_addr(rd_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [14:0] addr_of(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[6:0], lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic exp_ack, input string req);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
    chk(req, ack_o, exp_ack);
  endtask

  task automatic slot(input logic a, input string req);
    @(negedge clk); mack_vld = 1'b1; mack = a;
    @(negedge clk); mack_vld = 1'b0;
    exp_ctr = exp_ctr + 1'b1;
    chk(req, rd_addr, exp_ctr);
    chk(req, tx_en, a);
  endtask

  task automatic load_addr(input logic [7:0] hi, input logic [7:0] lo);
    do_start();
    send_byte(8'hA0, 1'b1, "R2");
    send_byte(hi, 1'b1, "R2");
    send_byte(lo, 1'b1, "R2");
    exp_ctr = addr_of(hi, lo);
    chk("R2", rd_addr, exp_ctr);
  endtask

  task automatic read_run(input int n_more);
    do_start();
    send_byte(8'hA1, 1'b1, "R5");
    chk("R5", tx_en, 1'b1);
    chk("R5", rd_addr, exp_ctr);
    for (int i = 0; i < n_more; i++) slot(1'b1, "R6");
    slot(1'b0, "R7");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd5183);
    rst_n = 1'b0; byte_vld = 1'b0; byte_data = 8'h00; start_evt = 1'b0;
    stop_evt = 1'b0; mack_vld = 1'b0; mack = 1'b0; wr_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ack_o, 1'b0);
    chk("R1", tx_en, 1'b0);
    chk("R1", rd_addr, 15'h0);
    exp_ctr = 15'h0;

    // current-address read from reset, then ignored byte after nack
    read_run(1);
    send_byte(8'hA1, 1'b0, "R7");
    do_stop();

    // random read, top bit of high byte ignored
    load_addr(8'h92, 8'h34);
    chk("R2", rd_addr, 15'h1234);
    read_run(2);
    do_stop();

    // wrap at the array end
    load_addr(8'h7F, 8'hFE);
    read_run(2);
    chk("R8", rd_addr, 15'h0001);

    // acknowledge polling during a write cycle
    wr_busy = 1'b1;
    do_start();
    send_byte(8'hA0, 1'b0, "R3");
    send_byte(8'hA0, 1'b0, "R3");
    wr_busy = 1'b0;
    send_byte(8'hA0, 1'b0, "R3");
    do_start();
    send_byte(8'hA0, 1'b1, "R3");
    do_stop();

    // select mismatch
    do_start();
    send_byte(8'hB1, 1'b0, "R4");
    send_byte(8'hA1, 1'b0, "R4");
    do_start();
    send_byte(8'hA3, 1'b0, "R4");
    chk("R4", tx_en, 1'b0);

    // write data bytes leave counter alone
    load_addr(8'h01, 8'h10);
    send_byte(8'h55, 1'b1, "R11");
    send_byte(8'hAA, 1'b1, "R11");
    chk("R11", rd_addr, 15'h0110);
    do_start();
    send_byte(8'hA1, 1'b1, "R5");
    chk("R11", rd_addr, 15'h0110);

    // start coinciding with master ack slot
    @(negedge clk); start_evt = 1'b1; mack_vld = 1'b1; mack = 1'b1;
    @(negedge clk); start_evt = 1'b0; mack_vld = 1'b0;
    chk("R9", rd_addr, 15'h0110);
    chk("R9", tx_en, 1'b0);
    send_byte(8'hA1, 1'b1, "R9");
    chk("R9", rd_addr, 15'h0110);

    // stop during read
    do_stop();
    chk("R10", tx_en, 1'b0);
    send_byte(8'hA1, 1'b0, "R10");

    // start coinciding with a select byte
    @(negedge clk); start_evt = 1'b1; byte_vld = 1'b1; byte_data = 8'hA1;
    @(negedge clk); start_evt = 1'b0; byte_vld = 1'b0;
    chk("R9", ack_o, 1'b0);
    chk("R9", tx_en, 1'b0);
    send_byte(8'hA1, 1'b1, "R9");
    chk("R9", tx_en, 1'b1);
    slot(1'b0, "R7");
    do_stop();

    // random reads, some near the top of the array
    for (int k = 0; k < 40; k++) begin
      logic [7:0] h, l;
      h = 8'($urandom);
      l = 8'($urandom);
      if (k % 3 == 0) begin h = 8'hFF; l = 8'hFC | 8'($urandom % 4); end
      if (k % 5 != 4) load_addr(h, l);
      read_run(int'($urandom % 6));
      if (k % 2 == 0) do_stop();
    end
    chk("R8", rd_addr, exp_ctr);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule